// File: doc/BRIEF.md
# UART Interrupt Cause Identification

This block gathers the interrupt conditions of one UART channel. It reduces them to a single reported cause, which it returns in an 8-bit status byte. The conditions come from the receive path, the transmit path, the modem lines and the flow-control logic. Each condition is first masked by its own enable bit. The two flow-control causes are also masked by an enhanced-feature enable. The block drives a level interrupt request for as long as any qualified cause is pending. Software reads the status byte to find the cause to service. The byte shows only the most urgent cause, so a less urgent one appears only on a later read, after the urgent one has gone away.

Five causes are event-style and are held by one small two-state machine each (`uart_irq_evlatch`). These are line error, transmit-holding empty, modem change, Xoff detected and flow-control change. The states are `EV_IDLE` (nothing held) and `EV_PEND` (cause held). The transition `EV_IDLE -> EV_PEND` is taken on the set pulse. The transition `EV_PEND -> EV_IDLE` is taken on the clear condition, but only when no set pulse arrives in the same cycle. Each machine has its own clear condition:
- line error, modem change and flow-control change: a dedicated clear strobe
- Xoff: the Xon-received pulse
- transmit empty: a transmit-byte write, or a status read that reports transmit empty

Receive data ready and receive time-out are level inputs. The status byte is registered on the read strobe and holds its value between reads.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the status byte reads 0x01 and `irq` is 0.
- R2: Bit 0 of the status byte is 0 when a cause is reported and 1 when none is. Bits 5:0 encode the cause as follows:
  - line error: 000110
  - receive ready: 000100
  - receive time-out: 001100
  - transmit empty: 000010
  - modem change: 000000
  - Xoff: 010000
  - flow-control change: 100000
  - nothing pending: 000001
- R3: When several qualified causes are pending, the one reported is the first in this order: line error, receive ready, receive time-out, transmit empty, modem change, Xoff, flow-control change.
- R4: When `enh_en` is 0, the Xoff and flow-control causes are neither reported nor counted for `irq`. Bits 5:4 of any byte captured then are 00.
- R5: Once an Xoff detection is held, it stays pending until `xon_det` is pulsed. Status reads and other clears do not remove it.
- R6: Bits 7:6 of the captured byte are 11 when `fifo_en` is 1 and 00 when it is 0.
- R7: `src_en` bit i qualifies cause i, with bit 0 = line error, 1 = receive ready, 2 = time-out, 3 = transmit empty, 4 = modem, 5 = Xoff, 6 = flow. `irq` is 1 exactly when some qualified cause is pending. Masking a cause does not discard its held state.
- R8: The transmit-empty cause is cleared by a read that reports it, or by a `thr_write` pulse.
- R9: Line error, modem change and flow-control change stay pending after their set pulse until their own clear strobe arrives.
- R10: The status byte changes only on a clock edge where `rd_stb` is 1. A cause that arrives between reads does not alter it.
- R11: If a set pulse and its clear arrive in the same cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 7 | Per-cause enable, bit order as in R7 |
| enh_en | input | 1 | Enhanced-feature enable for the Xoff and flow causes |
| fifo_en | input | 1 | FIFO mode flag, reported in bits 7:6 |
| line_err_set | input | 1 | Pulse: receive line error seen |
| line_err_clr | input | 1 | Pulse: clear the line error cause |
| rx_ready | input | 1 | Level: receive data available |
| rx_timeout | input | 1 | Level: receive time-out active |
| thr_empty_set | input | 1 | Pulse: transmit holding register became empty |
| thr_write | input | 1 | Pulse: new transmit byte written |
| modem_set | input | 1 | Pulse: modem input changed |
| modem_clr | input | 1 | Pulse: clear the modem cause |
| xoff_det | input | 1 | Pulse: Xoff or special character matched |
| xon_det | input | 1 | Pulse: Xon character received |
| flow_set | input | 1 | Pulse: CTS/RTS changed state |
| flow_clr | input | 1 | Pulse: clear the flow-change cause |
| rd_stb | input | 1 | Status read strobe |
| status | output | 8 | Registered status byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:
- the status byte holds between read strobes
- the FIFO flag bits and the enhanced-gating bits match the inputs sampled at the read
- bit 0 of a captured byte agrees with `irq` at the read
- the Xoff hold and the transmit-empty clear follow their state machines

The scoreboard scenarios are the only place where the full priority order, the exact cause codes and the masking by `src_en` are shown. They also show that a less urgent cause surfaces only on a later read, and that set wins over a clear in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC  = 7;
    localparam int NLAT  = 5;
    localparam int SRC_W = $clog2(NSRC + 1);

    typedef enum logic [SRC_W-1:0] {
        SRC_LINE  = 3'd0,
        SRC_RXRDY = 3'd1,
        SRC_RXTO  = 3'd2,
        SRC_THRE  = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_XOFF  = 3'd5,
        SRC_FLOW  = 3'd6,
        SRC_NONE  = 3'd7
    } irq_src_e;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_PEND = 1'b1
    } ev_state_e;

    // Cause code in bits 5:0 of the status byte (bit 0 low when pending)
    function automatic logic [5:0] src_code(irq_src_e s);
        logic [5:0] c;
        unique case (s)
            SRC_LINE:  c = 6'b000110;
            SRC_RXRDY: c = 6'b000100;
            SRC_RXTO:  c = 6'b001100;
            SRC_THRE:  c = 6'b000010;
            SRC_MODEM: c = 6'b000000;
            SRC_XOFF:  c = 6'b010000;
            SRC_FLOW:  c = 6'b100000;
            default:   c = 6'b000001;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_evlatch.sv
module uart_irq_evlatch
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    ev_state_e state_q;
    ev_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a set pulse beats a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: if (set_i)           state_d = EV_PEND;
            EV_PEND: if (clr_i && !set_i) state_d = EV_IDLE;
            default:                      state_d = EV_IDLE;
        endcase
    end

    // Output
    always_comb begin
        pend_o = (state_q == EV_PEND);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output irq_src_e        top_o
);

    // Lowest index has highest priority; scan downward so it wins last
    always_comb begin
        top_o = SRC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                top_o = irq_src_e'(SRC_W'(i));
            end
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_en,
    input  logic            enh_en,
    input  logic            fifo_en,
    input  logic            line_err_set,
    input  logic            line_err_clr,
    input  logic            rx_ready,
    input  logic            rx_timeout,
    input  logic            thr_empty_set,
    input  logic            thr_write,
    input  logic            modem_set,
    input  logic            modem_clr,
    input  logic            xoff_det,
    input  logic            xon_det,
    input  logic            flow_set,
    input  logic            flow_clr,
    input  logic            rd_stb,
    output logic [7:0]      status,
    output logic            irq
);

    // Latched cause slots
    localparam int L_LINE  = 0;
    localparam int L_THRE  = 1;
    localparam int L_MODEM = 2;
    localparam int L_XOFF  = 3;
    localparam int L_FLOW  = 4;

    logic [NLAT-1:0] lat_set;
    logic [NLAT-1:0] lat_clr;
    logic [NLAT-1:0] lat_q;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] gate;
    logic [NSRC-1:0] qual;
    irq_src_e        top;
    logic            thr_clr;
    logic [7:0]      stat_q;

    assign thr_clr = thr_write || (rd_stb && (top == SRC_THRE));

    always_comb begin
        lat_set          = '0;
        lat_clr          = '0;
        lat_set[L_LINE]  = line_err_set;
        lat_clr[L_LINE]  = line_err_clr;
        lat_set[L_THRE]  = thr_empty_set;
        lat_clr[L_THRE]  = thr_clr;
        lat_set[L_MODEM] = modem_set;
        lat_clr[L_MODEM] = modem_clr;
        lat_set[L_XOFF]  = xoff_det;
        lat_clr[L_XOFF]  = xon_det;
        lat_set[L_FLOW]  = flow_set;
        lat_clr[L_FLOW]  = flow_clr;
    end

    for (genvar g = 0; g < NLAT; g++) begin : g_lat
        uart_irq_evlatch u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (lat_set[g]),
            .clr_i  (lat_clr[g]),
            .pend_o (lat_q[g])
        );
    end

    // Map held and level conditions onto priority order
    always_comb begin
        raw            = '0;
        raw[SRC_LINE]  = lat_q[L_LINE];
        raw[SRC_RXRDY] = rx_ready;
        raw[SRC_RXTO]  = rx_timeout;
        raw[SRC_THRE]  = lat_q[L_THRE];
        raw[SRC_MODEM] = lat_q[L_MODEM];
        raw[SRC_XOFF]  = lat_q[L_XOFF];
        raw[SRC_FLOW]  = lat_q[L_FLOW];
        gate           = src_en;
        gate[SRC_XOFF] = src_en[SRC_XOFF] && enh_en;
        gate[SRC_FLOW] = src_en[SRC_FLOW] && enh_en;
        qual           = raw & gate;
    end

    uart_irq_prio u_prio (
        .req_i (qual),
        .top_o (top)
    );

    // Status byte captured only on the read strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 8'h01;
        end else if (rd_stb) begin
            stat_q <= {{2{fifo_en}}, src_code(top)};
        end
    end

    always_comb begin
        status = stat_q;
        irq    = |qual;
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       enh_en,
    input logic       fifo_en,
    input logic       irq,
    input logic [7:0] status,
    input logic       xoff_det,
    input logic       xon_det,
    input logic       xoff_pend,
    input logic       thr_write,
    input logic       thr_empty_set,
    input logic       thr_pend
);

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(status));

    // R6
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (status[7:6] == {2{$past(fifo_en)}}));

    // R4
    enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !enh_en) |=> (status[5:4] == 2'b00));

    // R7
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && irq) |=> !status[0]);

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !irq) |=> status[0]);

    // R5
    xoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_pend && !xon_det) |=> xoff_pend);

    // R11
    xoff_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_det |=> xoff_pend);

    // R8
    thr_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write && !thr_empty_set) |=> !thr_pend);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_stb        (rd_stb),
    .enh_en        (enh_en),
    .fifo_en       (fifo_en),
    .irq           (irq),
    .status        (status),
    .xoff_det      (xoff_det),
    .xon_det       (xon_det),
    .xoff_pend     (lat_q[3]),
    .thr_write     (thr_write),
    .thr_empty_set (thr_empty_set),
    .thr_pend      (lat_q[1])
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_en = 7'h7F;
    logic       enh_en = 1'b1;
    logic       fifo_en = 1'b1;
    logic       line_err_set = 1'b0, line_err_clr = 1'b0;
    logic       rx_ready = 1'b0, rx_timeout = 1'b0;
    logic       thr_empty_set = 1'b0, thr_write = 1'b0;
    logic       modem_set = 1'b0, modem_clr = 1'b0;
    logic       xoff_det = 1'b0, xon_det = 1'b0;
    logic       flow_set = 1'b0, flow_clr = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .enh_en(enh_en),
        .fifo_en(fifo_en), .line_err_set(line_err_set),
        .line_err_clr(line_err_clr), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .thr_empty_set(thr_empty_set),
        .thr_write(thr_write), .modem_set(modem_set),
        .modem_clr(modem_clr), .xoff_det(xoff_det), .xon_det(xon_det),
        .flow_set(flow_set), .flow_clr(flow_clr), .rd_stb(rd_stb),
        .status(status), .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Driver: queue the expected byte, then strobe a read
    task automatic read_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare the byte captured at the previous read edge
    always @(posedge clk) rd_d <= rd_stb;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(status == e, t, status, e);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        check(status == 8'h01, "R1 status", status, 8'h01);
        check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        read_expect(8'hC1, "R6 fifo on, idle");

        // R9 modem held; R2 code
        modem_set = 1'b1; @(negedge clk); modem_set = 1'b0;
        check(irq == 1'b1, "R7 irq modem", {7'd0, irq}, 8'h01);
        read_expect(8'hC0, "R2 modem code");
        read_expect(8'hC0, "R9 modem held");

        // R3 tx over modem, R8 read clears tx
        thr_empty_set = 1'b1; @(negedge clk); thr_empty_set = 1'b0;
        read_expect(8'hC2, "R3 tx over modem");
        read_expect(8'hC0, "R8 tx cleared by read");

        // R2/R3 line error, rx ready, time-out
        line_err_set = 1'b1; @(negedge clk); line_err_set = 1'b0;
        rx_ready = 1'b1;
        read_expect(8'hC6, "R3 line over rx");
        line_err_clr = 1'b1; @(negedge clk); line_err_clr = 1'b0;
        read_expect(8'hC4, "R2 rx ready code");
        rx_timeout = 1'b1;
        read_expect(8'hC4, "R3 rx ready over timeout");
        rx_ready = 1'b0;
        read_expect(8'hCC, "R2 timeout code");
        rx_timeout = 1'b0;
        modem_clr = 1'b1; @(negedge clk); modem_clr = 1'b0;
        read_expect(8'hC1, "R9 modem cleared");

        // R4 enhanced gating
        enh_en = 1'b0;
        xoff_det = 1'b1; @(negedge clk); xoff_det = 1'b0;
        check(irq == 1'b0, "R4 irq gated", {7'd0, irq}, 8'h00);
        read_expect(8'hC1, "R4 xoff hidden");
        enh_en = 1'b1;
        idle(1);
        check(irq == 1'b1, "R4 irq enhanced", {7'd0, irq}, 8'h01);
        read_expect(8'hD0, "R2 xoff code");
        flow_set = 1'b1; @(negedge clk); flow_set = 1'b0;
        read_expect(8'hD0, "R3 xoff over flow");
        flow_clr = 1'b1; line_err_clr = 1'b1; modem_clr = 1'b1;
        @(negedge clk);
        flow_clr = 1'b0; line_err_clr = 1'b0; modem_clr = 1'b0;
        read_expect(8'hD0, "R5 xoff sticky");
        flow_set = 1'b1; @(negedge clk); flow_set = 1'b0;
        xon_det = 1'b1; @(negedge clk); xon_det = 1'b0;
        read_expect(8'hE0, "R5 xon releases");
        flow_clr = 1'b1; @(negedge clk); flow_clr = 1'b0;
        read_expect(8'hC1, "R9 flow cleared");

        // R6 legacy mode
        fifo_en = 1'b0;
        read_expect(8'h01, "R6 fifo off");

        // R7 mask keeps held state
        src_en = 7'h7E;
        line_err_set = 1'b1; @(negedge clk); line_err_set = 1'b0;
        check(irq == 1'b0, "R7 masked irq", {7'd0, irq}, 8'h00);
        read_expect(8'h01, "R7 masked line");
        src_en = 7'h7F;
        read_expect(8'h06, "R7 unmasked line");
        line_err_clr = 1'b1; @(negedge clk); line_err_clr = 1'b0;

        // R8 write clears tx
        thr_empty_set = 1'b1; @(negedge clk); thr_empty_set = 1'b0;
        thr_write = 1'b1; @(negedge clk); thr_write = 1'b0;
        check(irq == 1'b0, "R8 irq after write", {7'd0, irq}, 8'h00);
        read_expect(8'h01, "R8 tx cleared by write");

        // R10 no read -> byte unchanged
        modem_set = 1'b1; @(negedge clk); modem_set = 1'b0;
        idle(2);
        check(status == 8'h01, "R10 stable", status, 8'h01);
        read_expect(8'h00, "R10 new cause on read");

        // R11 set wins over clear
        modem_clr = 1'b1; @(negedge clk); modem_clr = 1'b0;
        modem_set = 1'b1; modem_clr = 1'b1; @(negedge clk);
        modem_set = 1'b0; modem_clr = 1'b0;
        read_expect(8'h00, "R11 set wins");

        idle(3);
        check(exp_q.size() == 0, "scoreboard drained",
              8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule